// File: doc/BRIEF.md
# Data Access Translation Checker

This block takes one data load or store per cycle and decides how it reaches memory. It returns a physical address, an uncacheable flag, a single fault code and a memory-management status word. The request carries a virtual address, an access size, a store flag and three request flags: physical bypass, alternate-mode and page-table-entry fetch. It also carries the low bit of the current PC, the current-mode and alternate-mode registers, and the result of a lookup already performed in a separate TLB array. The checks run in a fixed order, and the first one that fails supplies the only fault reported. The block also keeps six event counters: hits, misses and access violations, each split by loads and stores.

A request is presented with `req_valid` high for one cycle. The response is registered and appears on the next clock edge with `rsp_valid` high. The response outputs keep their values until the next request arrives. The block does not refill the TLB and does not handle faults.

Top module: `dtx_top`

## Requirements
- R1: After reset, every response output and every counter is zero. A request accepted at a clock edge produces `rsp_valid`=1 and its results at that same edge. On a cycle with no request, `rsp_valid` is 0 and the counters and the other response outputs hold. When the fault code is nonzero, `rsp_pa` and `rsp_uncached` are 0.
- R2: Alignment is checked before anything else. A request whose VA ANDed with (2^size − 1) is nonzero gets fault code 1 (alignment). Its status is only the write bit (bit 0) for a store. No counter moves.
- R3: The effective mode is 2 bits wide, with kernel = 0. With `pc_lsb`=1 it is `alt_mode` when `flag_alt`=1 and kernel otherwise. With `pc_lsb`=0 it is `cur_mode`. The permission bit used is bit [effective mode] of the entry's enable masks.
- R4: A request with `flag_phys`=1 skips translation, and PA = VA. No counter moves.
- R5: A VA whose bits 63:47 are not all equal is invalid. It gets fault code 2 (page). Its status sets access-violation (bit 1), bad-VA (bit 4) and, for a store, write (bit 0). It adds one to the load or store violation counter.
- R6: VA[47:41] = 7'h7E is the superpage window. If `cur_mode` is not kernel, the request gets fault code 3 (violation) with status access-violation plus write for a store, and one violation count. Otherwise PA = VA[39:0], with PA[43:40] set to 4'hF when VA[40]=1. No counter moves.
- R7: A TLB miss gives fault code 4. If `flag_pte`=1 it gives fault code 5 instead. Its status sets miss (bit 5) plus write for a store, and the miss counter for that access kind adds one.
- R8: On a TLB hit, PA = (PPN << 13) + VA[12:0].
- R9: On a hit, a store whose write-enable bit is clear gets fault code 2, with status write + violation, plus fault-on-write (bit 3) if the entry's fault-on-write is set. A load whose read-enable bit is clear gets fault code 3, with status violation, plus fault-on-read (bit 2) if the entry's fault-on-read is set. Either case adds one violation count.
- R10: On a hit with permission granted, a set fault-on-write (store) or fault-on-read (load) gives fault code 2. The status is write + fault-on-write for a store, or fault-on-read alone for a load. It adds one violation count.
- R11: A hit that passes permission and fault-on checks adds one to the load or store hit counter, even if a later address check fails.
- R12: Any nonzero PA bit at position 44 or above gives fault code 6 (machine check) with status zero.
- R13: If PA[43]=1 and PA[43:20] are all ones, the request gets fault code 7 (unimplemented space). If PA[43]=1 otherwise, `rsp_uncached`=1 and PA[42:35] are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| va | input | 64 | Virtual address |
| size_log2 | input | 2 | Access size as log2 of bytes (0..3) |
| is_wr | input | 1 | 1 = store, 0 = load |
| flag_phys | input | 1 | Physical bypass request |
| flag_alt | input | 1 | Use alternate mode in privileged code |
| flag_pte | input | 1 | Request is a page-table-entry fetch |
| pc_lsb | input | 1 | PC bit 0 (privileged code when 1) |
| cur_mode | input | 2 | Current-mode register |
| alt_mode | input | 2 | Alternate-mode register |
| tlb_hit | input | 1 | TLB lookup matched |
| tlb_ppn | input | 36 | Physical page number of the matched entry |
| tlb_rd_en | input | 4 | Per-mode read enables of the entry |
| tlb_wr_en | input | 4 | Per-mode write enables of the entry |
| tlb_fonr | input | 1 | Entry fault-on-read |
| tlb_fonw | input | 1 | Entry fault-on-write |
| rsp_valid | output | 1 | Response valid |
| rsp_pa | output | 64 | Physical address |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_fault | output | 3 | Fault code |
| rsp_stat | output | 6 | Status word |
| cnt_rd_hit | output | 16 | Load hit count |
| cnt_rd_miss | output | 16 | Load miss count |
| cnt_rd_acv | output | 16 | Load violation count |
| cnt_wr_hit | output | 16 | Store hit count |
| cnt_wr_miss | output | 16 | Store miss count |
| cnt_wr_acv | output | 16 | Store violation count |

## Verification
Several checks can fail on one request, and only the earliest in the order may win. The bench stacks these conflicts on purpose. It sends a misaligned store to an invalid address. It sends a superpage access from a non-kernel current mode while the PC bit would force kernel. It sends a load that both lacks read permission and has fault-on-read set. It also sends a TLB hit whose translated PA lies beyond the implemented width, where the hit still counts but the fault is a machine check. Each case is judged on the fault code, on the full status word and on which single counter moved.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_ALIGN    = 3'd1,
      FLT_PAGE     = 3'd2,
      FLT_ACV      = 3'd3,
      FLT_MISS     = 3'd4,
      FLT_MISS_PTE = 3'd5,
      FLT_MCHK     = 3'd6,
      FLT_UNIMP    = 3'd7
   } flt_e;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_HIT  = 2'd1,
      EV_MISS = 2'd2,
      EV_ACV  = 2'd3
   } ev_e;

   localparam int ST_W     = 6;
   localparam int ST_WR    = 0;
   localparam int ST_ACV   = 1;
   localparam int ST_FONR  = 2;
   localparam int ST_FONW  = 3;
   localparam int ST_BADVA = 4;
   localparam int ST_MISS  = 5;

   localparam int N_CNT = 6;

endpackage

// File: rtl/dtx_mode_sel.sv
module dtx_mode_sel #(
   parameter int MODE_W = 2
) (
   input  logic              pc_lsb,
   input  logic              use_alt,
   input  logic [MODE_W-1:0] cur_mode,
   input  logic [MODE_W-1:0] alt_mode,
   output logic [MODE_W-1:0] eff_mode
);
   localparam logic [MODE_W-1:0] KERNEL = '0;

   always_comb begin
      if (!pc_lsb)      eff_mode = cur_mode;
      else if (use_alt) eff_mode = alt_mode;
      else              eff_mode = KERNEL;
   end
endmodule

// File: rtl/dtx_xlate.sv
module dtx_xlate
   import dtx_pkg::*;
#(
   parameter int VA_W     = 64,
   parameter int VA_SIG   = 48,
   parameter int PA_IMPL  = 44,
   parameter int PG_SHIFT = 13,
   parameter int PPN_W    = 36,
   parameter int MODE_W   = 2
) (
   input  logic                   [VA_W-1:0]  va,
   input  logic                   [1:0]       size_log2,
   input  logic                               is_wr,
   input  logic                               flag_phys,
   input  logic                               flag_pte,
   input  logic                   [MODE_W-1:0] cur_mode,
   input  logic                   [MODE_W-1:0] eff_mode,
   input  logic                               tlb_hit,
   input  logic                   [PPN_W-1:0] tlb_ppn,
   input  logic                   [(1<<MODE_W)-1:0] tlb_rd_en,
   input  logic                   [(1<<MODE_W)-1:0] tlb_wr_en,
   input  logic                               tlb_fonr,
   input  logic                               tlb_fonw,
   output logic                   [VA_W-1:0]  pa,
   output logic                               do_pa,
   output flt_e                               flt,
   output logic                   [ST_W-1:0]  stat,
   output ev_e                                ev
);
   localparam int SP_HI   = VA_SIG - 1;
   localparam int SP_LO   = VA_SIG - 7;
   localparam int UC_BIT  = PA_IMPL - 1;
   localparam int EXT_BIT = PA_IMPL - 4;
   localparam logic [MODE_W-1:0] KERNEL = '0;

   logic [2:0]      amask;
   logic            misalign;
   logic            va_ok;
   logic            in_sp;
   logic [VA_W-1:0] sp_pa;
   logic [VA_W-1:0] hit_pa;
   logic            perm_ok;
   logic            fon;

   assign amask    = 3'((4'd1 << size_log2) - 4'd1);
   assign misalign = |(va[2:0] & amask);
   assign va_ok    = (&va[VA_W-1:VA_SIG-1]) | ~(|va[VA_W-1:VA_SIG-1]);
   assign in_sp    = (va[SP_HI:SP_LO] == 7'h7E);
   assign hit_pa   = VA_W'({tlb_ppn, va[PG_SHIFT-1:0]});
   assign perm_ok  = is_wr ? tlb_wr_en[eff_mode] : tlb_rd_en[eff_mode];
   assign fon      = is_wr ? tlb_fonw : tlb_fonr;

   always_comb begin
      sp_pa = '0;
      sp_pa[EXT_BIT-1:0] = va[EXT_BIT-1:0];
      if (va[EXT_BIT]) sp_pa[UC_BIT:EXT_BIT] = '1;
   end

   always_comb begin
      flt   = FLT_NONE;
      stat  = '0;
      ev    = EV_NONE;
      pa    = '0;
      do_pa = 1'b0;
      if (misalign) begin
         flt         = FLT_ALIGN;
         stat[ST_WR] = is_wr;
      end else if (flag_phys) begin
         pa    = va;
         do_pa = 1'b1;
      end else if (!va_ok) begin
         flt            = FLT_PAGE;
         stat[ST_WR]    = is_wr;
         stat[ST_BADVA] = 1'b1;
         stat[ST_ACV]   = 1'b1;
         ev             = EV_ACV;
      end else if (in_sp) begin
         if (cur_mode != KERNEL) begin
            flt          = FLT_ACV;
            stat[ST_WR]  = is_wr;
            stat[ST_ACV] = 1'b1;
            ev           = EV_ACV;
         end else begin
            pa    = sp_pa;
            do_pa = 1'b1;
         end
      end else if (!tlb_hit) begin
         flt           = flag_pte ? FLT_MISS_PTE : FLT_MISS;
         stat[ST_WR]   = is_wr;
         stat[ST_MISS] = 1'b1;
         ev            = EV_MISS;
      end else begin
         pa = hit_pa;
         if (!perm_ok) begin
            flt           = is_wr ? FLT_PAGE : FLT_ACV;
            stat[ST_WR]   = is_wr;
            stat[ST_ACV]  = 1'b1;
            stat[ST_FONW] = is_wr & tlb_fonw;
            stat[ST_FONR] = ~is_wr & tlb_fonr;
            ev            = EV_ACV;
         end else if (fon) begin
            flt           = FLT_PAGE;
            stat[ST_WR]   = is_wr;
            stat[ST_FONW] = is_wr;
            stat[ST_FONR] = ~is_wr;
            ev            = EV_ACV;
         end else begin
            ev    = EV_HIT;
            do_pa = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dtx_pa_chk.sv
module dtx_pa_chk
   import dtx_pkg::*;
#(
   parameter int VA_W    = 64,
   parameter int PA_IMPL = 44,
   parameter int IPR_LO  = 20
) (
   input  logic [VA_W-1:0] pa_in,
   output logic [VA_W-1:0] pa_out,
   output logic            uncached,
   output flt_e            flt
);
   localparam int UC_BIT = PA_IMPL - 1;
   localparam int CLR_HI = PA_IMPL - 2;
   localparam int CLR_LO = PA_IMPL - 9;

   always_comb begin
      pa_out   = pa_in;
      uncached = 1'b0;
      flt      = FLT_NONE;
      if (|pa_in[VA_W-1:PA_IMPL]) begin
         flt = FLT_MCHK;
      end else if (pa_in[UC_BIT]) begin
         if (&pa_in[UC_BIT:IPR_LO]) begin
            flt = FLT_UNIMP;
         end else begin
            uncached              = 1'b1;
            pa_out[CLR_HI:CLR_LO] = '0;
         end
      end
   end
endmodule

// File: rtl/dtx_ctr_bank.sv
module dtx_ctr_bank #(
   parameter int N     = 6,
   parameter int CNT_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N-1:0]              inc,
   output logic [N-1:0][CNT_W-1:0]   cnt
);
   for (genvar g = 0; g < N; g++) begin : g_ctr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt[g] <= '0;
         else if (inc[g]) cnt[g] <= cnt[g] + 1'b1;
      end
   end
endmodule

// File: rtl/dtx_top.sv
module dtx_top
   import dtx_pkg::*;
#(
   parameter int VA_W     = 64,
   parameter int VA_SIG   = 48,
   parameter int PA_IMPL  = 44,
   parameter int PG_SHIFT = 13,
   parameter int PPN_W    = 36,
   parameter int MODE_W   = 2,
   parameter int IPR_LO   = 20,
   parameter int CNT_W    = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [VA_W-1:0]          va,
   input  logic [1:0]               size_log2,
   input  logic                     is_wr,
   input  logic                     flag_phys,
   input  logic                     flag_alt,
   input  logic                     flag_pte,
   input  logic                     pc_lsb,
   input  logic [MODE_W-1:0]        cur_mode,
   input  logic [MODE_W-1:0]        alt_mode,
   input  logic                     tlb_hit,
   input  logic [PPN_W-1:0]         tlb_ppn,
   input  logic [(1<<MODE_W)-1:0]   tlb_rd_en,
   input  logic [(1<<MODE_W)-1:0]   tlb_wr_en,
   input  logic                     tlb_fonr,
   input  logic                     tlb_fonw,
   output logic                     rsp_valid,
   output logic [VA_W-1:0]          rsp_pa,
   output logic                     rsp_uncached,
   output logic [2:0]               rsp_fault,
   output logic [5:0]               rsp_stat,
   output logic [CNT_W-1:0]         cnt_rd_hit,
   output logic [CNT_W-1:0]         cnt_rd_miss,
   output logic [CNT_W-1:0]         cnt_rd_acv,
   output logic [CNT_W-1:0]         cnt_wr_hit,
   output logic [CNT_W-1:0]         cnt_wr_miss,
   output logic [CNT_W-1:0]         cnt_wr_acv
);
   if (VA_SIG <= PA_IMPL || VA_SIG > VA_W)
      $fatal(1, "dtx_top: VA_SIG must exceed PA_IMPL and fit in VA_W");
   if (PA_IMPL <= IPR_LO + 1 || PA_IMPL < 12)
      $fatal(1, "dtx_top: PA_IMPL too small for the uncached decode");
   if (PPN_W + PG_SHIFT > VA_W || PG_SHIFT < 3)
      $fatal(1, "dtx_top: page geometry does not fit the address width");

   logic [MODE_W-1:0] eff_mode;
   logic [VA_W-1:0]   xl_pa;
   logic              xl_do_pa;
   flt_e              xl_flt;
   logic [ST_W-1:0]   xl_stat;
   ev_e               xl_ev;
   logic [VA_W-1:0]   pc_pa;
   logic              pc_unc;
   flt_e              pc_flt;
   flt_e              fin_flt;
   logic [N_CNT-1:0]  inc;
   logic [N_CNT-1:0][CNT_W-1:0] cnt;

   dtx_mode_sel #(.MODE_W(MODE_W)) u_mode (
      .pc_lsb   (pc_lsb),
      .use_alt  (flag_alt),
      .cur_mode (cur_mode),
      .alt_mode (alt_mode),
      .eff_mode (eff_mode)
   );

   dtx_xlate #(
      .VA_W(VA_W), .VA_SIG(VA_SIG), .PA_IMPL(PA_IMPL),
      .PG_SHIFT(PG_SHIFT), .PPN_W(PPN_W), .MODE_W(MODE_W)
   ) u_xl (
      .va        (va),
      .size_log2 (size_log2),
      .is_wr     (is_wr),
      .flag_phys (flag_phys),
      .flag_pte  (flag_pte),
      .cur_mode  (cur_mode),
      .eff_mode  (eff_mode),
      .tlb_hit   (tlb_hit),
      .tlb_ppn   (tlb_ppn),
      .tlb_rd_en (tlb_rd_en),
      .tlb_wr_en (tlb_wr_en),
      .tlb_fonr  (tlb_fonr),
      .tlb_fonw  (tlb_fonw),
      .pa        (xl_pa),
      .do_pa     (xl_do_pa),
      .flt       (xl_flt),
      .stat      (xl_stat),
      .ev        (xl_ev)
   );

   dtx_pa_chk #(.VA_W(VA_W), .PA_IMPL(PA_IMPL), .IPR_LO(IPR_LO)) u_pac (
      .pa_in    (xl_pa),
      .pa_out   (pc_pa),
      .uncached (pc_unc),
      .flt      (pc_flt)
   );

   assign fin_flt = xl_do_pa ? pc_flt : xl_flt;

   always_comb begin
      inc = '0;
      if (req_valid) begin
         case (xl_ev)
            EV_HIT:  inc[is_wr ? 3 : 0] = 1'b1;
            EV_MISS: inc[is_wr ? 4 : 1] = 1'b1;
            EV_ACV:  inc[is_wr ? 5 : 2] = 1'b1;
            default: inc = '0;
         endcase
      end
   end

   dtx_ctr_bank #(.N(N_CNT), .CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc),
      .cnt   (cnt)
   );

   assign cnt_rd_hit  = cnt[0];
   assign cnt_rd_miss = cnt[1];
   assign cnt_rd_acv  = cnt[2];
   assign cnt_wr_hit  = cnt[3];
   assign cnt_wr_miss = cnt[4];
   assign cnt_wr_acv  = cnt[5];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_pa       <= '0;
         rsp_uncached <= 1'b0;
         rsp_fault    <= '0;
         rsp_stat     <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault    <= fin_flt;
            rsp_stat     <= xl_stat;
            rsp_pa       <= (fin_flt == FLT_NONE) ? pc_pa : '0;
            rsp_uncached <= (fin_flt == FLT_NONE) ? pc_unc : 1'b0;
         end
      end
   end
endmodule

// File: rtl/dtx_chk.sv
module dtx_chk #(
   parameter int VA_W    = 64,
   parameter int PA_IMPL = 44,
   parameter int CNT_W   = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [VA_W-1:0]  va,
   input logic [1:0]       size_log2,
   input logic             flag_phys,
   input logic             rsp_valid,
   input logic [VA_W-1:0]  rsp_pa,
   input logic             rsp_uncached,
   input logic [2:0]       rsp_fault,
   input logic [5:0]       rsp_stat,
   input logic [CNT_W-1:0] cnt_rd_hit,
   input logic [CNT_W-1:0] cnt_wr_acv
);
   localparam int UC_BIT = PA_IMPL - 1;
   localparam int CLR_HI = PA_IMPL - 2;
   localparam int CLR_LO = PA_IMPL - 9;

   logic [2:0] amask;
   logic       misal;
   assign amask = 3'((4'd1 << size_log2) - 4'd1);
   assign misal = |(va[2:0] & amask);

   // R2: misalignment wins over every other check
   a_r2_align_first: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && misal |=> rsp_fault == 3'd1 && rsp_pa == '0);

   // R4: physical bypass inside the implemented space passes the VA through
   a_r4_phys_pass: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !misal && flag_phys && va[VA_W-1:UC_BIT] == '0
      |=> rsp_pa == $past(va) && rsp_fault == 3'd0);

   // R13: an uncacheable response is fault-free with its high field cleared
   a_r13_uncached_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_uncached |-> rsp_fault == 3'd0 && rsp_pa[UC_BIT] && rsp_pa[CLR_HI:CLR_LO] == '0);

   // R7: both miss codes carry the miss status bit
   a_r7_miss_stat: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault == 3'd4 || rsp_fault == 3'd5) |-> rsp_stat[5]);

   // R12: machine check reports an empty status word
   a_r12_mchk_stat: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault == 3'd6 |-> rsp_stat == 6'd0);

   // R1: an idle cycle moves no counter and raises no response
   a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && $stable(cnt_rd_hit) && $stable(cnt_wr_acv) && $stable(rsp_fault));
endmodule

bind dtx_top dtx_chk #(.VA_W(VA_W), .PA_IMPL(PA_IMPL), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .va           (va),
   .size_log2    (size_log2),
   .flag_phys    (flag_phys),
   .rsp_valid    (rsp_valid),
   .rsp_pa       (rsp_pa),
   .rsp_uncached (rsp_uncached),
   .rsp_fault    (rsp_fault),
   .rsp_stat     (rsp_stat),
   .cnt_rd_hit   (cnt_rd_hit),
   .cnt_wr_acv   (cnt_wr_acv)
);

// File: tb/dtx_top_tb_top.sv
`timescale 1ns/1ps
module dtx_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] va = '0;
   logic [1:0]  size_log2 = '0;
   logic        is_wr = 1'b0, flag_phys = 1'b0, flag_alt = 1'b0, flag_pte = 1'b0, pc_lsb = 1'b0;
   logic [1:0]  cur_mode = '0, alt_mode = '0;
   logic        tlb_hit = 1'b0;
   logic [35:0] tlb_ppn = '0;
   logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
   logic        tlb_fonr = 1'b0, tlb_fonw = 1'b0;
   logic        rsp_valid, rsp_uncached;
   logic [63:0] rsp_pa;
   logic [2:0]  rsp_fault;
   logic [5:0]  rsp_stat;
   logic [15:0] cnt_rd_hit, cnt_rd_miss, cnt_rd_acv, cnt_wr_hit, cnt_wr_miss, cnt_wr_acv;

   always #4 clk = ~clk;

   dtx_top dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va), .size_log2(size_log2),
      .is_wr(is_wr), .flag_phys(flag_phys), .flag_alt(flag_alt), .flag_pte(flag_pte),
      .pc_lsb(pc_lsb), .cur_mode(cur_mode), .alt_mode(alt_mode), .tlb_hit(tlb_hit),
      .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
      .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
      .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault), .rsp_stat(rsp_stat),
      .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss), .cnt_rd_acv(cnt_rd_acv),
      .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss), .cnt_wr_acv(cnt_wr_acv)
   );

   typedef struct packed {
      logic [63:0] va;  logic [1:0] sz; logic wr; logic phys; logic alt; logic pte; logic pcl;
      logic [1:0]  cur; logic [1:0] altm; logic hit; logic [35:0] ppn;
      logic [3:0]  rde; logic [3:0] wre; logic fonr; logic fonw;
      logic [63:0] epa; logic eunc; logic [2:0] eflt; logic [5:0] est; logic [1:0] ev; logic [4:0] rq;
   } vec_t;

   // ev: 0 none, 1 hit, 2 miss, 3 violation
   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      // R2 misaligned store to an invalid VA: alignment wins
      '{64'h8000_0000_0000_0004, 2'd3, 1,0,0,0,0, 2'd0,2'd0, 0, 36'h0, 4'h0,4'h0, 0,0,
        64'h0, 0, 3'd1, 6'b000001, 2'd0, 5'd2},
      // R4 physical bypass
      '{64'h0000_0000_1234_5678, 2'd2, 0,1,0,0,0, 2'd0,2'd0, 0, 36'h0, 4'h0,4'h0, 0,0,
        64'h0000_0000_1234_5678, 0, 3'd0, 6'b000000, 2'd0, 5'd4},
      // R5 invalid VA load
      '{64'h0001_0000_0000_0000, 2'd0, 0,0,0,0,0, 2'd0,2'd0, 1, 36'h1, 4'hF,4'hF, 0,0,
        64'h0, 0, 3'd2, 6'b010010, 2'd3, 5'd5},
      // R5 invalid VA store
      '{64'h0001_0000_0000_0000, 2'd0, 1,0,0,0,0, 2'd0,2'd0, 1, 36'h1, 4'hF,4'hF, 0,0,
        64'h0, 0, 3'd2, 6'b010011, 2'd3, 5'd5},
      // R6 superpage from non-kernel current mode, PC bit would force kernel
      '{64'hFFFF_FC00_0000_1000, 2'd0, 0,0,0,0,1, 2'd1,2'd0, 1, 36'h1, 4'hF,4'hF, 0,0,
        64'h0, 0, 3'd3, 6'b000010, 2'd3, 5'd6},
      // R6 kernel superpage, bit 40 clear
      '{64'hFFFF_FC12_3456_7000, 2'd3, 0,0,0,0,0, 2'd0,2'd0, 0, 36'h0, 4'h0,4'h0, 0,0,
        64'h0000_0012_3456_7000, 0, 3'd0, 6'b000000, 2'd0, 5'd6},
      // R6 with R13: bit 40 set, extended, uncached, field cleared
      '{64'hFFFF_FD00_0000_2000, 2'd0, 0,0,0,0,0, 2'd0,2'd0, 0, 36'h0, 4'h0,4'h0, 0,0,
        64'h0000_0800_0000_2000, 1, 3'd0, 6'b000000, 2'd0, 5'd13},
      // R13 register space
      '{64'hFFFF_FDFF_FFF0_0000, 2'd0, 0,0,0,0,0, 2'd0,2'd0, 0, 36'h0, 4'h0,4'h0, 0,0,
        64'h0, 0, 3'd7, 6'b000000, 2'd0, 5'd13},
      // R7 store miss
      '{64'h0000_0000_0000_4000, 2'd3, 1,0,0,0,0, 2'd0,2'd0, 0, 36'h0, 4'h0,4'h0, 0,0,
        64'h0, 0, 3'd4, 6'b100001, 2'd2, 5'd7},
      // R7 page-table-entry fetch miss
      '{64'h0000_0000_0000_4000, 2'd3, 0,0,0,1,0, 2'd0,2'd0, 0, 36'h0, 4'h0,4'h0, 0,0,
        64'h0, 0, 3'd5, 6'b100000, 2'd2, 5'd7},
      // R8 load hit
      '{64'h0000_0000_0001_2345, 2'd0, 0,0,0,0,0, 2'd0,2'd0, 1, 36'h0_000A_BCDE, 4'b0001,4'h0, 0,0,
        64'h0000_0001_579B_C345, 0, 3'd0, 6'b000000, 2'd1, 5'd8},
      // R3 alternate mode 3 selected, read-enable clear, fault-on-read reported (R9)
      '{64'h0000_0000_0001_2345, 2'd0, 0,0,1,0,1, 2'd0,2'd3, 1, 36'h0_000A_BCDE, 4'b0111,4'h0, 1,0,
        64'h0, 0, 3'd3, 6'b000110, 2'd3, 5'd3},
      // R3 PC bit set without alt flag: kernel overrides current mode 2
      '{64'h0000_0000_0001_2345, 2'd0, 0,0,0,0,1, 2'd2,2'd3, 1, 36'h0_000A_BCDE, 4'b0001,4'h0, 0,0,
        64'h0000_0001_579B_C345, 0, 3'd0, 6'b000000, 2'd1, 5'd3},
      // R9 store without write-enable, fault-on-write reported
      '{64'h0000_0000_0001_2345, 2'd0, 1,0,0,0,0, 2'd1,2'd0, 1, 36'h0_000A_BCDE, 4'hF,4'b1101, 0,1,
        64'h0, 0, 3'd2, 6'b001011, 2'd3, 5'd9},
      // R10 store fault-on-write alone
      '{64'h0000_0000_0001_2345, 2'd0, 1,0,0,0,0, 2'd1,2'd0, 1, 36'h0_000A_BCDE, 4'hF,4'hF, 0,1,
        64'h0, 0, 3'd2, 6'b001001, 2'd3, 5'd10},
      // R10 load fault-on-read alone
      '{64'h0000_0000_0001_2345, 2'd0, 0,0,0,0,0, 2'd1,2'd0, 1, 36'h0_000A_BCDE, 4'hF,4'hF, 1,0,
        64'h0, 0, 3'd2, 6'b000100, 2'd3, 5'd10},
      // R11 store hit in mode 1
      '{64'h0000_0000_0001_2345, 2'd0, 1,0,0,0,0, 2'd1,2'd0, 1, 36'h0_000A_BCDE, 4'h0,4'b0010, 0,0,
        64'h0000_0001_579B_C345, 0, 3'd0, 6'b000000, 2'd1, 5'd11},
      // R12 hit whose PA exceeds the implemented width; hit still counted (R11)
      '{64'h0000_0000_0001_2345, 2'd0, 0,0,0,0,0, 2'd0,2'd0, 1, 36'h8_0000_0000, 4'hF,4'h0, 0,0,
        64'h0, 0, 3'd6, 6'b000000, 2'd1, 5'd12},
      // R12 physical bypass beyond implemented width
      '{64'h0000_1000_0000_0000, 2'd0, 0,1,0,0,0, 2'd0,2'd0, 0, 36'h0, 4'h0,4'h0, 0,0,
        64'h0, 0, 3'd6, 6'b000000, 2'd0, 5'd12},
      // R13 translated PA in uncached space
      '{64'h0000_0000_0001_2345, 2'd0, 0,0,0,0,0, 2'd0,2'd0, 1, 36'h0_7FC0_0001, 4'hF,4'h0, 0,0,
        64'h0000_0800_0000_2345, 1, 3'd0, 6'b000000, 2'd1, 5'd13}
   };

   int n_chk = 0;
   int n_bad = 0;
   int ecnt [6];

   task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic chk_cnts(input string rq);
      chk(rq, "cnt_rd_hit",  64'(cnt_rd_hit),  64'(ecnt[0]));
      chk(rq, "cnt_rd_miss", 64'(cnt_rd_miss), 64'(ecnt[1]));
      chk(rq, "cnt_rd_acv",  64'(cnt_rd_acv),  64'(ecnt[2]));
      chk(rq, "cnt_wr_hit",  64'(cnt_wr_hit),  64'(ecnt[3]));
      chk(rq, "cnt_wr_miss", 64'(cnt_wr_miss), 64'(ecnt[4]));
      chk(rq, "cnt_wr_acv",  64'(cnt_wr_acv),  64'(ecnt[5]));
   endtask

   task automatic apply(input vec_t v);
      string rq;
      rq = $sformatf("R%0d", v.rq);
      @(negedge clk);
      va = v.va; size_log2 = v.sz; is_wr = v.wr; flag_phys = v.phys; flag_alt = v.alt;
      flag_pte = v.pte; pc_lsb = v.pcl; cur_mode = v.cur; alt_mode = v.altm; tlb_hit = v.hit;
      tlb_ppn = v.ppn; tlb_rd_en = v.rde; tlb_wr_en = v.wre; tlb_fonr = v.fonr; tlb_fonw = v.fonw;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (v.ev != 2'd0) ecnt[(v.wr ? 3 : 0) + int'(v.ev) - 1]++;
      chk(rq, "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(rq, "rsp_pa", rsp_pa, v.epa);
      chk(rq, "rsp_uncached", 64'(rsp_uncached), 64'(v.eunc));
      chk(rq, "rsp_fault", 64'(rsp_fault), 64'(v.eflt));
      chk(rq, "rsp_stat", 64'(rsp_stat), 64'(v.est));
      chk_cnts(rq);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 6; i++) ecnt[i] = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "reset rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R1", "reset rsp_pa", rsp_pa, 64'd0);
      chk("R1", "reset rsp_fault", 64'(rsp_fault), 64'd0);
      chk("R1", "reset rsp_stat", 64'(rsp_stat), 64'd0);
      chk_cnts("R1");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) apply(VEC[i]);

      // R1 idle cycle: valid drops, outputs and counters hold
      @(negedge clk);
      chk("R1", "idle rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R1", "idle rsp_pa", rsp_pa, VEC[NV-1].epa);
      chk("R1", "idle rsp_uncached", 64'(rsp_uncached), 64'd1);
      chk_cnts("R1");

      // R2 misaligned halfword load on an otherwise clean hit
      apply('{64'h0000_0000_0001_2341, 2'd1, 0,0,0,0,0, 2'd0,2'd0, 1, 36'h1, 4'hF,4'hF, 0,0,
              64'h0, 0, 3'd1, 6'b000000, 2'd0, 5'd2});
      // R8 aligned quadword hit at page offset zero
      apply('{64'h0000_0000_0000_2000, 2'd3, 0,0,0,0,0, 2'd0,2'd0, 1, 36'h0_0000_0003, 4'hF,4'h0, 0,0,
              64'h0000_0000_0000_6000, 0, 3'd0, 6'b000000, 2'd1, 5'd8});

      // R1 reset clears the counters
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 6; i++) ecnt[i] = 0;
      chk_cnts("R1");
      chk("R1", "reset rsp_fault", 64'(rsp_fault), 64'd0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule